// File: doc/BRIEF.md
# TLB Miss Walk Sequencer

This block is the control sequencer that decides what happens when a memory-stage instruction starts while the instruction TLB, the data TLB, or both report a miss. In the ready state it samples three inputs: instruction-side miss, data-side miss and memory-operation valid. It then hands the data cache to the hardware page-table walker for as many walks as are needed, one at a time and data side first. It turns each walk result into a TLB write strobe or a fault report. Finally it lets the pending memory access complete, with a replayed cache lookup, or aborts it.

The pipeline stall stays asserted for the whole sequence. While a walk is in flight, the arbiter select gives the cache to the walker. The walker and the cache are reached through simple pulse handshakes. The walker receives a one-cycle start with a side tag and answers with a one-cycle done that may carry a fault bit. The cache answers a memory access with a one-cycle acknowledge.

Top module: `tlb_walk_seq`

## Requirements
- R1: A synchronous reset, including one in the middle of a sequence, returns the block to ready at the next edge. After that edge the stall, the arbiter select and every pulse output are low.
- R2: In the ready state, a data-side miss without a memory operation is illegal. That covers both the case with an instruction-side miss and the case without one. In that cycle `illegal_o` is high, no walk is started and the stall stays low.
- R3: A memory operation with no misses starts no walk. The stall is held from the cycle after sampling until the cache acknowledge. The stall is low in the cycle after the acknowledge.
- R4: When both TLBs miss, the walks run in a fixed order: the data walk first, then the instruction walk, then the memory access.
- R5: A data walk that ends in a fault pulses `dfault_o` and `abort_o` on the done cycle. It skips any pending instruction walk, gives no replay and no memory access, and the stall is low in the next cycle.
- R6: An instruction walk that ends in a fault pulses `ifault_o`. A concurrent memory operation still completes through replay and acknowledge.
- R7: An instruction-side miss without a memory operation runs exactly one walk. That walk ends in either `itlb_wr_o` or `ifault_o`, and the stall is low in the cycle after the done.
- R8: `walk_sel_o` is high in every cycle from the walk start through its done, and low outside walks.
- R9: After walks end with the memory operation still pending, `replay_o` is high for exactly one cycle. That cycle comes before the cache acknowledge is accepted, and `walk_sel_o` is low during it.
- R10: A successful data walk pulses `dtlb_wr_o` on its done cycle. That pulse comes before the replay and before the memory access finishes.
- R11: `walk_start_o` is a single-cycle pulse, and `walk_side_o` is 1 for a data walk and 0 for an instruction walk. The strobes `itlb_wr_o`, `dtlb_wr_o`, `ifault_o`, `dfault_o` and `abort_o` appear only in a walker done cycle, and at most one of the four TLB strobes is high at a time.
- R12: The miss and operation inputs have no effect outside the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| itlb_miss_i | input | 1 | Instruction TLB miss |
| dtlb_miss_i | input | 1 | Data TLB miss |
| memop_i | input | 1 | Memory operation valid |
| walk_done_i | input | 1 | Walker finished (one-cycle pulse) |
| walk_fault_i | input | 1 | Walk ended in a fault; valid with done |
| cache_ack_i | input | 1 | Cache finished the memory access |
| stall_o | output | 1 | Pipeline stall |
| walk_sel_o | output | 1 | Arbiter select: walker owns the cache |
| walk_start_o | output | 1 | Walk start pulse |
| walk_side_o | output | 1 | Walk side tag, 1 = data, 0 = instruction |
| itlb_wr_o | output | 1 | Instruction TLB write strobe |
| dtlb_wr_o | output | 1 | Data TLB write strobe |
| ifault_o | output | 1 | Instruction-side page fault |
| dfault_o | output | 1 | Data-side page fault |
| replay_o | output | 1 | Replay the memory access into the cache |
| abort_o | output | 1 | Abort the memory access |
| illegal_o | output | 1 | Illegal miss combination sampled |

## Verification
The sharpest overlap is a data walk and an instruction walk triggered by the same sampled cycle. The bench provokes it by raising both miss inputs together with the memory operation. It then judges the order of the start pulses by their side tags, and checks which strobes fire under each fault pattern. A second overlap is a fault report in the same cycle as the abort decision. A data fault must end the sequence at once, while an instruction fault with a pending access must still lead to replay and acknowledge. The bench drives the walker stub with a fault on one side or the other and checks the strobe set and the stall release.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      S_READY  = 3'd0,
      S_DSTART = 3'd1,
      S_DWAIT  = 3'd2,
      S_ISTART = 3'd3,
      S_IWAIT  = 3'd4,
      S_REPLAY = 3'd5,
      S_MEM    = 3'd6
   } seq_state_e;

   typedef enum logic [2:0] {
      C_IDLE,
      C_MEM,
      C_DWALK,
      C_IWALK,
      C_ILLEGAL
   } miss_class_e;

   localparam logic SIDE_DATA  = 1'b1;
   localparam logic SIDE_INSTR = 1'b0;
endpackage

// File: rtl/tws_classify.sv
module tws_classify
   import tws_pkg::*;
(
   input  logic        imiss_i,
   input  logic        dmiss_i,
   input  logic        memop_i,
   output miss_class_e cls_o
);
   always_comb begin
      if (dmiss_i && !memop_i)      cls_o = C_ILLEGAL;
      else if (dmiss_i)             cls_o = C_DWALK;
      else if (imiss_i)             cls_o = C_IWALK;
      else if (memop_i)             cls_o = C_MEM;
      else                          cls_o = C_IDLE;
   end
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
   import tws_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_i,
   input  miss_class_e cls_i,
   input  logic        imiss_i,
   input  logic        memop_i,
   input  logic        done_i,
   input  logic        fault_i,
   input  logic        ack_i,
   output seq_state_e  state_o
);
   seq_state_e state_q, state_d;
   logic       pend_i_q, pend_i_d;
   logic       pend_m_q, pend_m_d;

   always_comb begin
      state_d  = state_q;
      pend_i_d = pend_i_q;
      pend_m_d = pend_m_q;
      unique case (state_q)
         S_READY: begin
            unique case (cls_i)
               C_DWALK: begin
                  state_d  = S_DSTART;
                  pend_i_d = imiss_i;
                  pend_m_d = 1'b1;
               end
               C_IWALK: begin
                  state_d  = S_ISTART;
                  pend_i_d = 1'b0;
                  pend_m_d = memop_i;
               end
               C_MEM:   state_d = S_MEM;
               default: state_d = S_READY;
            endcase
         end
         S_DSTART: state_d = S_DWAIT;
         S_DWAIT: begin
            if (done_i) begin
               if (fault_i)       state_d = S_READY;
               else if (pend_i_q) state_d = S_ISTART;
               else               state_d = S_REPLAY;
            end
         end
         S_ISTART: state_d = S_IWAIT;
         S_IWAIT: begin
            if (done_i) state_d = pend_m_q ? S_REPLAY : S_READY;
         end
         S_REPLAY: state_d = S_MEM;
         S_MEM: begin
            if (ack_i) state_d = S_READY;
         end
         default: state_d = S_READY;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q  <= S_READY;
         pend_i_q <= 1'b0;
         pend_m_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         pend_i_q <= pend_i_d;
         pend_m_q <= pend_m_d;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/tws_outdec.sv
module tws_outdec
   import tws_pkg::*;
(
   input  seq_state_e  state_i,
   input  miss_class_e cls_i,
   input  logic        done_i,
   input  logic        fault_i,
   output logic        stall_o,
   output logic        walk_sel_o,
   output logic        walk_start_o,
   output logic        walk_side_o,
   output logic        itlb_wr_o,
   output logic        dtlb_wr_o,
   output logic        ifault_o,
   output logic        dfault_o,
   output logic        replay_o,
   output logic        abort_o,
   output logic        illegal_o
);
   logic d_end, i_end;

   assign d_end = (state_i == S_DWAIT) && done_i;
   assign i_end = (state_i == S_IWAIT) && done_i;

   assign stall_o      = (state_i != S_READY);
   assign walk_sel_o   = (state_i == S_DSTART) || (state_i == S_DWAIT) ||
                         (state_i == S_ISTART) || (state_i == S_IWAIT);
   assign walk_start_o = (state_i == S_DSTART) || (state_i == S_ISTART);
   assign walk_side_o  = (state_i == S_DSTART) ? SIDE_DATA : SIDE_INSTR;
   assign dtlb_wr_o    = d_end && !fault_i;
   assign dfault_o     = d_end && fault_i;
   assign abort_o      = d_end && fault_i;
   assign itlb_wr_o    = i_end && !fault_i;
   assign ifault_o     = i_end && fault_i;
   assign replay_o     = (state_i == S_REPLAY);
   assign illegal_o    = (state_i == S_READY) && (cls_i == C_ILLEGAL);
endmodule

// File: rtl/tlb_walk_seq.sv
module tlb_walk_seq
   import tws_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic itlb_miss_i,
   input  logic dtlb_miss_i,
   input  logic memop_i,
   input  logic walk_done_i,
   input  logic walk_fault_i,
   input  logic cache_ack_i,
   output logic stall_o,
   output logic walk_sel_o,
   output logic walk_start_o,
   output logic walk_side_o,
   output logic itlb_wr_o,
   output logic dtlb_wr_o,
   output logic ifault_o,
   output logic dfault_o,
   output logic replay_o,
   output logic abort_o,
   output logic illegal_o
);
   miss_class_e cls;
   seq_state_e  state;

   tws_classify u_cls (
      .imiss_i (itlb_miss_i),
      .dmiss_i (dtlb_miss_i),
      .memop_i (memop_i),
      .cls_o   (cls)
   );

   tws_fsm u_fsm (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cls_i   (cls),
      .imiss_i (itlb_miss_i),
      .memop_i (memop_i),
      .done_i  (walk_done_i),
      .fault_i (walk_fault_i),
      .ack_i   (cache_ack_i),
      .state_o (state)
   );

   tws_outdec u_dec (
      .state_i      (state),
      .cls_i        (cls),
      .done_i       (walk_done_i),
      .fault_i      (walk_fault_i),
      .stall_o      (stall_o),
      .walk_sel_o   (walk_sel_o),
      .walk_start_o (walk_start_o),
      .walk_side_o  (walk_side_o),
      .itlb_wr_o    (itlb_wr_o),
      .dtlb_wr_o    (dtlb_wr_o),
      .ifault_o     (ifault_o),
      .dfault_o     (dfault_o),
      .replay_o     (replay_o),
      .abort_o      (abort_o),
      .illegal_o    (illegal_o)
   );
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
   input logic clk_i,
   input logic rst_i,
   input logic walk_done_i,
   input logic cache_ack_i,
   input logic stall_o,
   input logic walk_sel_o,
   input logic walk_start_o,
   input logic itlb_wr_o,
   input logic dtlb_wr_o,
   input logic ifault_o,
   input logic dfault_o,
   input logic replay_o,
   input logic abort_o,
   input logic illegal_o
);
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      rst_i |=> (!stall_o && !walk_sel_o && !walk_start_o && !replay_o));

   p_illegal_nowalk_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      illegal_o |-> (!stall_o && !walk_start_o));

   p_ack_release_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (stall_o && !walk_sel_o && !replay_o && cache_ack_i) |=> !stall_o);

   p_dfault_abort_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      dfault_o |-> abort_o);

   p_dfault_release_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      dfault_o |=> !stall_o);

   p_start_sel_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      walk_start_o |-> (walk_sel_o && stall_o));

   p_replay_owner_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      replay_o |-> (stall_o && !walk_sel_o));

   p_replay_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      replay_o |=> !replay_o);

   p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      walk_start_o |=> !walk_start_o);

   p_strobe_onehot_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({itlb_wr_o, dtlb_wr_o, ifault_o, dfault_o}));

   p_strobe_done_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (itlb_wr_o || dtlb_wr_o || ifault_o || dfault_o || abort_o) |->
      (walk_done_i && walk_sel_o));
endmodule

bind tlb_walk_seq tws_checker u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .walk_done_i  (walk_done_i),
   .cache_ack_i  (cache_ack_i),
   .stall_o      (stall_o),
   .walk_sel_o   (walk_sel_o),
   .walk_start_o (walk_start_o),
   .itlb_wr_o    (itlb_wr_o),
   .dtlb_wr_o    (dtlb_wr_o),
   .ifault_o     (ifault_o),
   .dfault_o     (dfault_o),
   .replay_o     (replay_o),
   .abort_o      (abort_o),
   .illegal_o    (illegal_o)
);

// File: tb/tlb_walk_seq_tb_top.sv
module tlb_walk_seq_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic imiss = 1'b0, dmiss = 1'b0, memop = 1'b0;
   logic wdone = 1'b0, wfault = 1'b0, ack = 1'b0;
   logic stall_o, walk_sel_o, walk_start_o, walk_side_o;
   logic itlb_wr_o, dtlb_wr_o, ifault_o, dfault_o;
   logic replay_o, abort_o, illegal_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tlb_walk_seq dut_i (
      .clk_i(clk), .rst_i(rst),
      .itlb_miss_i(imiss), .dtlb_miss_i(dmiss), .memop_i(memop),
      .walk_done_i(wdone), .walk_fault_i(wfault), .cache_ack_i(ack),
      .stall_o(stall_o), .walk_sel_o(walk_sel_o),
      .walk_start_o(walk_start_o), .walk_side_o(walk_side_o),
      .itlb_wr_o(itlb_wr_o), .dtlb_wr_o(dtlb_wr_o),
      .ifault_o(ifault_o), .dfault_o(dfault_o),
      .replay_o(replay_o), .abort_o(abort_o), .illegal_o(illegal_o)
   );

   // Vector: [16:12] = {imiss, dmiss, memop, ifault, dfault}
   // Expected [11:0] = {proto_err, first_side_data, n_starts[1:0],
   //                    dtlb_wr, itlb_wr, dfault, ifault, abort, replay, mem_done, illegal}
   localparam int NV = 13;
   localparam logic [16:0] VEC [NV] = '{
      {5'b000_00, 12'b0_0_00_0000_0_0_0_0},
      {5'b001_00, 12'b0_0_00_0000_0_0_1_0},
      {5'b011_00, 12'b0_1_01_1000_0_1_1_0},
      {5'b011_01, 12'b0_1_01_0010_1_0_0_0},
      {5'b100_00, 12'b0_0_01_0100_0_0_0_0},
      {5'b100_10, 12'b0_0_01_0001_0_0_0_0},
      {5'b101_00, 12'b0_0_01_0100_0_1_1_0},
      {5'b101_10, 12'b0_0_01_0001_0_1_1_0},
      {5'b111_00, 12'b0_1_10_1100_0_1_1_0},
      {5'b111_10, 12'b0_1_10_1001_0_1_1_0},
      {5'b111_01, 12'b0_1_01_0010_1_0_0_0},
      {5'b010_00, 12'b0_0_00_0000_0_0_0_1},
      {5'b110_00, 12'b0_0_00_0000_0_0_0_1}
   };

   function automatic string req_of(input int idx);
      case (idx)
         0, 1:    return "R3";
         2:       return "R10";
         3, 10:   return "R5";
         4, 5:    return "R7";
         6:       return "R9";
         7, 9:    return "R6";
         8:       return "R4";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic run_case(input logic [4:0] v, output logic [11:0] res);
      int cd;
      int mc;
      logic cur_side;
      res = '0; cd = -1; mc = 0; cur_side = 1'b0;
      @(negedge clk);
      {imiss, dmiss, memop} = v[4:2];
      #1 res[0] = illegal_o;
      @(negedge clk);
      imiss = 1'b0; dmiss = 1'b0; memop = 1'b0;
      for (int k = 0; k < 60; k++) begin
         wdone = 1'b0; wfault = 1'b0; ack = 1'b0;
         #1;
         if (!stall_o) break;
         if (itlb_wr_o || dtlb_wr_o || ifault_o || dfault_o || abort_o) res[11] = 1'b1;
         if (walk_start_o) begin
            if (res[9:8] == 2'd0) res[10] = walk_side_o;
            res[9:8] = res[9:8] + 2'd1;
            cur_side = walk_side_o;
            cd = 2;
         end
         if (cd >= 0 && !walk_sel_o) res[11] = 1'b1;
         if (replay_o) res[2] = 1'b1;
         if (!walk_sel_o && !replay_o) begin
            mc++;
            if (mc == 2) begin ack = 1'b1; res[1] = 1'b1; end
         end
         if (cd > 0) cd--;
         else if (cd == 0) begin
            wdone = 1'b1;
            wfault = cur_side ? v[0] : v[1];
            cd = -1;
            #1;
            res[7] = res[7] | dtlb_wr_o;
            res[6] = res[6] | itlb_wr_o;
            res[5] = res[5] | dfault_o;
            res[4] = res[4] | ifault_o;
            res[3] = res[3] | abort_o;
         end
         @(negedge clk);
      end
      wdone = 1'b0; wfault = 1'b0; ack = 1'b0;
   endtask

   initial begin
      logic [11:0] got;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check("R1", {6'b0, stall_o, walk_sel_o, walk_start_o, itlb_wr_o, dtlb_wr_o,
                   ifault_o, dfault_o, replay_o, abort_o, illegal_o}, 16'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         run_case(VEC[i][16:12], got);
         check(req_of(i), {4'b0, got[10:0]} , {4'b0, VEC[i][10:0]});
         // R8 R11: select held during walks, strobes only on done
         check("R8 R11", {15'b0, got[11]}, 16'h0);
         #1 check("R3 stall end", {15'b0, stall_o}, 16'h0);
      end

      // R12 and R3: inputs ignored during the memory wait; release after ack
      @(negedge clk); memop = 1'b1;
      @(negedge clk); memop = 1'b0;
      for (int k = 0; k < 3; k++) begin
         imiss = 1'b1; dmiss = 1'b1;
         #1 check("R12", {14'b0, walk_start_o, illegal_o}, 16'h0);
         @(negedge clk);
      end
      imiss = 1'b0; dmiss = 1'b0;
      #1 check("R12 stall held", {15'b0, stall_o}, 16'h1);
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      #1 check("R3 release", {15'b0, stall_o}, 16'h0);

      // R1: reset in the middle of a data walk
      @(negedge clk); dmiss = 1'b1; memop = 1'b1;
      @(negedge clk); dmiss = 1'b0; memop = 1'b0;
      #1 check("R11 start side", {14'b0, walk_start_o, walk_side_o}, 16'h3);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      #1 check("R1 mid reset", {14'b0, stall_o, walk_sel_o}, 16'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 5000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule